// File: doc/BRIEF.md
# Calendar Real-Time Clock with Shadowed Register Access

This block keeps wall-clock time and a calendar. The counters hold a sub-second count, seconds, minutes, hours, day of week, day of month, month and a two-digit year, and they handle leap years. They advance on a 128 Hz strobe supplied in the processor clock domain. A separate 500 Hz strobe sets the pace for all traffic between the counters and the processor.

The processor never touches the counters directly. It reads and writes a bank of shadow words. The bank is copied from the counters on each 500 Hz strobe unless the processor holds it still. A freeze bit gives a stable snapshot to read. A write bit opens the bank for editing. When the write bit is cleared, the edited words are loaded into the counters on the following 500 Hz strobe. A change flag on each word limits the load to the words that were written. The counters can only be cleared by the dedicated RTC power-on reset. The general reset clears only the shadow side.

Register map, with 8-bit data: 0 control/status (bit 0 freeze, bit 1 write), 1 sub-second, 2 seconds, 3 minutes, 4 hours, 5 day of week, 6 day of month, 7 month, 8 year, 9 change flags (bit i belongs to address 2+i). Other addresses read 0. Register reads are combinational. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `rtc_calendar`

## Requirements
- R1: `rtc_por_n` sets the counters to 00:00:00, day of week 1, day 1, month 1, year 0. `rst_n` clears the control bits, the change flags and the shadow bank, but it leaves the counters unchanged.
- R2: Reading address 1 returns 127 minus the sub-second count, so it reads 127 right after a restart. Writing 0x00 to address 1 restarts the count at 0. Writing any non-zero value there has no effect.
- R3: The sub-second count wraps on the 128th `tick_128` strobe. In the cycle after that strobe, `sec_pulse` is high for exactly one cycle and the seconds counter has advanced.
- R4: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each day rollover advances the day of week, which wraps from 7 to 1.
- R5: Day of month wraps after 30 in months 4, 6, 9 and 11, and after 31 in the other non-February months. In February it wraps after 29 when the year is divisible by 4 and after 28 otherwise.
- R6: Month 12, day 31 rolls over to month 1, day 1 and increments the year. Year 99 wraps to 0.
- R7: While the freeze bit, the write bit and any pending commit are all clear, each `tick_500` strobe copies the counters into the shadow bank. Between strobes the shadow words do not change.
- R8: While the freeze bit is 1, no refresh takes place.
- R9: After the freeze bit is cleared, status bit 0 keeps reading 1 until the next refresh has completed.
- R10: Writes to the shadow words (addresses 2..8) are accepted only while the write bit is 1. Each accepted write sets that word's change flag. At any other time such writes change neither the words nor the flags.
- R11: After the write bit is cleared, the next `tick_500` loads only the flagged words into the counters and clears all change flags. Counters whose words were not flagged keep running.
- R12: After the write bit is cleared, status bit 1 keeps reading 1 until that load has happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-domain clock |
| rst_n | input | 1 | General active-low reset (shadow side only) |
| rtc_por_n | input | 1 | Active-low RTC power-on reset for the counters |
| tick_500 | input | 1 | One-cycle 500 Hz strobe for refresh and commit |
| tick_128 | input | 1 | One-cycle 128 Hz sub-second strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sec_pulse | output | 1 | One-cycle strobe at each one-second boundary |

## Verification
A register write shows up on the read port one cycle after its write cycle. The bench therefore drives each access at a falling edge and samples one nanosecond later on the next access. `sec_pulse` and the advanced seconds value appear in the cycle that follows the wrapping `tick_128` strobe, and the bench samples them at the falling edge right after that strobe is dropped. Refresh, status clearing and commit loads all land at the edge where `tick_500` is sampled. For that reason, every shadow or status check is made once before and once after a strobe, which shows both the held value and the updated one.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int DW       = 8;
  localparam int NWORDS   = 7;
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DOM  = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  typedef logic [NWORDS-1:0][DW-1:0] cal_words_t;

  // Number of days in a month; February grows by one in a leap year
  function automatic logic [DW-1:0] month_days(input logic [DW-1:0] mon,
                                               input logic [DW-1:0] year,
                                               input int leap_period);
    logic [DW-1:0] d;
    case (mon)
      8'd4, 8'd6, 8'd9, 8'd11: d = 8'd30;
      8'd2: d = ((int'(year) % leap_period) == 0) ? 8'd29 : 8'd28;
      default: d = 8'd31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rtc_cal_chain.sv
`timescale 1ns/1ps
module rtc_cal_chain
  import rtc_cal_pkg::*;
#(
  parameter int SUB_STEPS   = 128,
  parameter int YEAR_SPAN   = 100,
  parameter int LEAP_PERIOD = 4,
  localparam int SUB_W      = $clog2(SUB_STEPS)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              tick_sub,
  input  logic              sub_clr,
  input  logic [NWORDS-1:0] load_en,
  input  cal_words_t        load_val,
  output cal_words_t        cur,
  output logic [SUB_W-1:0]  sub_left,
  output logic              sec_pulse
);
  localparam logic [SUB_W-1:0] SUB_MAX  = SUB_W'(SUB_STEPS - 1);
  localparam logic [DW-1:0]    MS_MAX   = 8'd59;
  localparam logic [DW-1:0]    HOUR_MAX = 8'd23;
  localparam logic [DW-1:0]    DOW_MAX  = 8'd7;
  localparam logic [DW-1:0]    MON_MAX  = 8'd12;
  localparam logic [DW-1:0]    YEAR_MAX = DW'(YEAR_SPAN - 1);

  cal_words_t       cur_q, nxt;
  logic [SUB_W-1:0] sub_q;
  logic             wrap, pulse_q;

  assign wrap = tick_sub && (sub_q == SUB_MAX) && !sub_clr;

  always_comb begin
    nxt = cur_q;
    if (wrap) begin
      if (cur_q[IDX_SEC] >= MS_MAX) begin
        nxt[IDX_SEC] = '0;
        if (cur_q[IDX_MIN] >= MS_MAX) begin
          nxt[IDX_MIN] = '0;
          if (cur_q[IDX_HOUR] >= HOUR_MAX) begin
            nxt[IDX_HOUR] = '0;
            nxt[IDX_DOW]  = (cur_q[IDX_DOW] >= DOW_MAX) ? 8'd1 : cur_q[IDX_DOW] + 8'd1;
            if (cur_q[IDX_DOM] >= month_days(cur_q[IDX_MON], cur_q[IDX_YEAR], LEAP_PERIOD)) begin
              nxt[IDX_DOM] = 8'd1;
              if (cur_q[IDX_MON] >= MON_MAX) begin
                nxt[IDX_MON]  = 8'd1;
                nxt[IDX_YEAR] = (cur_q[IDX_YEAR] >= YEAR_MAX) ? '0 : cur_q[IDX_YEAR] + 8'd1;
              end else begin
                nxt[IDX_MON] = cur_q[IDX_MON] + 8'd1;
              end
            end else begin
              nxt[IDX_DOM] = cur_q[IDX_DOM] + 8'd1;
            end
          end else begin
            nxt[IDX_HOUR] = cur_q[IDX_HOUR] + 8'd1;
          end
        end else begin
          nxt[IDX_MIN] = cur_q[IDX_MIN] + 8'd1;
        end
      end else begin
        nxt[IDX_SEC] = cur_q[IDX_SEC] + 8'd1;
      end
    end
    // flagged words from a commit override the advanced value
    for (int i = 0; i < NWORDS; i++)
      if (load_en[i]) nxt[i] = load_val[i];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cur_q           <= '0;
      cur_q[IDX_DOW]  <= 8'd1;
      cur_q[IDX_DOM]  <= 8'd1;
      cur_q[IDX_MON]  <= 8'd1;
      sub_q           <= '0;
      pulse_q         <= 1'b0;
    end else begin
      cur_q   <= nxt;
      pulse_q <= wrap;
      if (sub_clr)       sub_q <= '0;
      else if (tick_sub) sub_q <= (sub_q == SUB_MAX) ? '0 : sub_q + 1'b1;
    end
  end

  assign cur       = cur_q;
  assign sub_left  = SUB_MAX - sub_q;
  assign sec_pulse = pulse_q;
endmodule

// File: rtl/rtc_cal_shadow.sv
`timescale 1ns/1ps
module rtc_cal_shadow
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ctrl_we,
  input  logic [NWORDS-1:0] word_we,
  input  logic [DW-1:0]     wdata,
  input  cal_words_t        cur,
  output cal_words_t        shadow,
  output logic [NWORDS-1:0] flags,
  output logic [NWORDS-1:0] load_en,
  output logic              frz_q,
  output logic              wr_q,
  output logic              frz_stat,
  output logic              wr_stat
);
  cal_words_t        shd_q;
  logic [NWORDS-1:0] flg_q;
  logic              frz_pend, cmt_pend;
  logic              refresh, commit;

  assign refresh = tick && !frz_q && !wr_q && !cmt_pend;
  assign commit  = tick && cmt_pend && !wr_q;
  assign load_en = flg_q & {NWORDS{commit}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q    <= '0;
      flg_q    <= '0;
      frz_q    <= 1'b0;
      wr_q     <= 1'b0;
      frz_pend <= 1'b0;
      cmt_pend <= 1'b0;
    end else begin
      if (refresh) begin
        shd_q    <= cur;
        frz_pend <= 1'b0;
      end
      if (commit) begin
        cmt_pend <= 1'b0;
        flg_q    <= '0;
      end
      if (ctrl_we) begin
        frz_q <= wdata[0];
        wr_q  <= wdata[1];
        if (frz_q && !wdata[0]) frz_pend <= 1'b1;
        if (wr_q && !wdata[1])  cmt_pend <= 1'b1;
      end
      for (int i = 0; i < NWORDS; i++) begin
        if (word_we[i] && wr_q) begin
          shd_q[i] <= wdata;
          flg_q[i] <= 1'b1;
        end
      end
    end
  end

  assign shadow   = shd_q;
  assign flags    = flg_q;
  assign frz_stat = frz_q | frz_pend;
  assign wr_stat  = wr_q | cmt_pend;
endmodule

// File: rtl/rtc_cal_regdec.sv
`timescale 1ns/1ps
module rtc_cal_regdec
  import rtc_cal_pkg::*;
#(
  parameter int AW    = 4,
  parameter int SUB_W = 7
) (
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              frz_stat,
  input  logic              wr_stat,
  input  logic [SUB_W-1:0]  sub_left,
  input  cal_words_t        shadow,
  input  logic [NWORDS-1:0] flags,
  output logic              ctrl_we,
  output logic [NWORDS-1:0] word_we,
  output logic              sub_clr,
  output logic [DW-1:0]     rdata
);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_SUB   = AW'(1);
  localparam int            A_WORD0 = 2;
  localparam logic [AW-1:0] A_FLAGS = AW'(A_WORD0 + NWORDS);

  assign ctrl_we = wr_en && (addr == A_CTRL);
  assign sub_clr = wr_en && (addr == A_SUB) && (wdata == '0);

  for (genvar g = 0; g < NWORDS; g++) begin : g_we
    assign word_we[g] = wr_en && (addr == AW'(A_WORD0 + g));
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)       rdata = {{(DW-2){1'b0}}, wr_stat, frz_stat};
    else if (addr == A_SUB)   rdata = DW'(sub_left);
    else if (addr == A_FLAGS) rdata = DW'(flags);
    else
      for (int i = 0; i < NWORDS; i++)
        if (addr == AW'(A_WORD0 + i)) rdata = shadow[i];
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int SUB_STEPS   = 128,
  parameter int YEAR_SPAN   = 100,
  parameter int LEAP_PERIOD = 4,
  parameter int AW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rtc_por_n,
  input  logic          tick_500,
  input  logic          tick_128,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sec_pulse
);
  localparam int SUB_W = $clog2(SUB_STEPS);

  cal_words_t        cur_w, shadow_w;
  logic [NWORDS-1:0] flags_w, load_en_w, word_we_w;
  logic [SUB_W-1:0]  sub_left_w;
  logic              ctrl_we_w, sub_clr_w;
  logic              frz_q_w, wr_q_w, frz_stat_w, wr_stat_w;

  rtc_cal_chain #(
    .SUB_STEPS(SUB_STEPS), .YEAR_SPAN(YEAR_SPAN), .LEAP_PERIOD(LEAP_PERIOD)
  ) u_chain (
    .clk(clk), .por_n(rtc_por_n), .tick_sub(tick_128), .sub_clr(sub_clr_w),
    .load_en(load_en_w), .load_val(shadow_w), .cur(cur_w),
    .sub_left(sub_left_w), .sec_pulse(sec_pulse)
  );

  rtc_cal_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .tick(tick_500), .ctrl_we(ctrl_we_w),
    .word_we(word_we_w), .wdata(reg_wdata), .cur(cur_w), .shadow(shadow_w),
    .flags(flags_w), .load_en(load_en_w), .frz_q(frz_q_w), .wr_q(wr_q_w),
    .frz_stat(frz_stat_w), .wr_stat(wr_stat_w)
  );

  rtc_cal_regdec #(.AW(AW), .SUB_W(SUB_W)) u_dec (
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .frz_stat(frz_stat_w), .wr_stat(wr_stat_w), .sub_left(sub_left_w),
    .shadow(shadow_w), .flags(flags_w), .ctrl_we(ctrl_we_w),
    .word_we(word_we_w), .sub_clr(sub_clr_w), .rdata(reg_rdata)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rtc_por_n,
  input logic       tick_500,
  input logic       sec_pulse,
  input logic       frz_q,
  input logic       wr_q,
  input logic       frz_stat,
  input logic       wr_stat,
  input cal_words_t shadow,
  input cal_words_t cur,
  input logic       load_sec
);
  AST_SEC_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !rtc_por_n)
    sec_pulse |=> !sec_pulse); // R3
  AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n || !rtc_por_n)
    (sec_pulse && !$past(load_sec)) |-> (cur[IDX_SEC] != $past(cur[IDX_SEC]))); // R3
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !rtc_por_n)
    (frz_q && !wr_q) |=> $stable(shadow)); // R8
  AST_FRZ_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n || !rtc_por_n)
    $fell(frz_stat) |-> $past(tick_500)); // R9
  AST_COMMIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n || !rtc_por_n)
    $fell(wr_stat) |-> $past(tick_500)); // R12
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rtc_por_n(rtc_por_n), .tick_500(tick_500),
  .sec_pulse(sec_pulse), .frz_q(frz_q_w), .wr_q(wr_q_w),
  .frz_stat(frz_stat_w), .wr_stat(wr_stat_w), .shadow(shadow_w),
  .cur(cur_w), .load_sec(load_en_w[0])
);

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
  localparam time CLK_T = 4ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, rtc_por_n = 1'b0;
  logic       tick_500 = 1'b0, tick_128 = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sec_pulse;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_T/2) clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .rtc_por_n(rtc_por_n), .tick_500(tick_500),
    .tick_128(tick_128), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_pulse(sec_pulse)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic expect_reg(string tag, input logic [3:0] a, input int exp);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic p500();
    @(negedge clk); tick_500 = 1'b1;
    @(negedge clk); tick_500 = 1'b0;
  endtask

  task automatic p128(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_128 = 1'b1;
      @(negedge clk); tick_128 = 1'b0;
    end
  endtask

  task automatic adv_sec();
    p128(127);
    @(negedge clk); tick_128 = 1'b1;
    @(negedge clk); tick_128 = 1'b0;
    chk("R3 sec_pulse high", int'(sec_pulse), 1);
    @(negedge clk);
    chk("R3 sec_pulse one cycle", int'(sec_pulse), 0);
  endtask

  task automatic set_time(input int s, mi, h, dw, dm, mo, y);
    wr(4'd0, 8'd2);
    wr(4'd2, 8'(s));  wr(4'd3, 8'(mi)); wr(4'd4, 8'(h));
    wr(4'd5, 8'(dw)); wr(4'd6, 8'(dm)); wr(4'd7, 8'(mo)); wr(4'd8, 8'(y));
    wr(4'd0, 8'd0);
    p500();
    p500();
    wr(4'd1, 8'd0);
  endtask

  task automatic expect_time(string tag, input int s, mi, h, dw, dm, mo, y);
    expect_reg({tag, " sec"}, 4'd2, s);
    expect_reg({tag, " min"}, 4'd3, mi);
    expect_reg({tag, " hour"}, 4'd4, h);
    expect_reg({tag, " dow"}, 4'd5, dw);
    expect_reg({tag, " dom"}, 4'd6, dm);
    expect_reg({tag, " mon"}, 4'd7, mo);
    expect_reg({tag, " year"}, 4'd8, y);
  endtask

  task automatic t_reset();
    expect_reg("R1 ctrl after reset", 4'd0, 0);
    expect_reg("R2 subsec after por", 4'd1, 127);
    p500();
    expect_time("R1 por defaults", 0, 0, 0, 1, 1, 1, 0);
  endtask

  task automatic t_subsec();
    p128(5);
    expect_reg("R2 subsec remaining", 4'd1, 122);
    wr(4'd1, 8'd5);
    expect_reg("R2 nonzero write ignored", 4'd1, 122);
    wr(4'd1, 8'd0);
    expect_reg("R2 zero write restarts", 4'd1, 127);
  endtask

  task automatic t_refresh();
    set_time(10, 0, 0, 1, 1, 1, 0);
    adv_sec();
    expect_reg("R7 shadow holds between ticks", 4'd2, 10);
    p500();
    expect_reg("R7 shadow refreshed on tick", 4'd2, 11);
  endtask

  task automatic t_rollover();
    set_time(59, 59, 23, 7, 31, 12, 99);
    adv_sec();
    p500();
    expect_time("R4 R6 year wrap", 0, 0, 0, 1, 1, 1, 0);
    set_time(59, 59, 23, 3, 31, 12, 41);
    adv_sec();
    p500();
    expect_time("R6 new year", 0, 0, 0, 4, 1, 1, 42);
  endtask

  task automatic t_months();
    set_time(59, 59, 23, 2, 28, 2, 24);
    adv_sec(); p500();
    expect_reg("R5 leap feb 29 dom", 4'd6, 29);
    expect_reg("R5 leap feb 29 mon", 4'd7, 2);
    set_time(59, 59, 23, 2, 28, 2, 23);
    adv_sec(); p500();
    expect_reg("R5 common feb dom", 4'd6, 1);
    expect_reg("R5 common feb mon", 4'd7, 3);
    set_time(59, 59, 23, 2, 30, 4, 23);
    adv_sec(); p500();
    expect_reg("R5 april dom", 4'd6, 1);
    expect_reg("R5 april mon", 4'd7, 5);
    set_time(59, 59, 23, 2, 30, 7, 23);
    adv_sec(); p500();
    expect_reg("R5 july 31st", 4'd6, 31);
  endtask

  task automatic t_freeze();
    set_time(20, 0, 0, 1, 1, 1, 0);
    wr(4'd0, 8'd1);
    adv_sec();
    p500();
    expect_reg("R8 frozen shadow", 4'd2, 20);
    expect_reg("R8 freeze status", 4'd0, 1);
    wr(4'd0, 8'd0);
    expect_reg("R9 status stays set", 4'd0, 1);
    expect_reg("R9 shadow still old", 4'd2, 20);
    p500();
    expect_reg("R9 status clears after refresh", 4'd0, 0);
    expect_reg("R9 shadow updated", 4'd2, 21);
  endtask

  task automatic t_commit();
    set_time(30, 5, 0, 1, 1, 1, 0);
    wr(4'd2, 8'd33);
    expect_reg("R10 shadow write ignored", 4'd2, 30);
    expect_reg("R10 no flag set", 4'd9, 0);
    wr(4'd0, 8'd2);
    adv_sec();
    wr(4'd3, 8'd45);
    expect_reg("R10 flag set for minutes", 4'd9, 2);
    wr(4'd0, 8'd0);
    expect_reg("R12 write status held", 4'd0, 2);
    expect_reg("R11 flags held until tick", 4'd9, 2);
    p500();
    expect_reg("R12 write status cleared", 4'd0, 0);
    expect_reg("R11 flags cleared", 4'd9, 0);
    p500();
    expect_reg("R11 flagged word loaded", 4'd3, 45);
    expect_reg("R11 unflagged word kept running", 4'd2, 31);
  endtask

  task automatic t_soft_reset();
    set_time(7, 8, 9, 3, 15, 6, 50);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_reg("R1 shadow cleared by rst_n", 4'd2, 0);
    p500();
    expect_time("R1 counters survive rst_n", 7, 8, 9, 3, 15, 6, 50);
  endtask

  initial begin
    #(CLK_T * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rtc_por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_subsec();
    t_refresh();
    t_rollover();
    t_months();
    t_freeze();
    t_commit();
    t_soft_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule